// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Receiver

This block turns an asynchronous serial line into bytes. It runs from a clock-enable tick at sixteen times the bit rate. While reception is enabled it watches the line all the time. A low level starts a frame, and the block accepts that start only if the line is still low half a bit later. It then samples each bit at the centre of its bit time. The frame holds eight data bits, least significant first. A ninth bit may follow, and a single stop bit closes the frame.

In normal mode the ninth bit is present only when parity is enabled, and it is checked as odd or even parity. In multiprocessor mode the ninth bit is always present. It is kept as an address/data marker and is never checked. Every completed frame raises the receive-data-full flag, even when the frame had an error, and any parity, framing or overrun error is flagged alongside. The host reads the byte with a read strobe, which clears the full flag, and clears the error flags with a separate strobe. A receive interrupt follows the full flag whenever interrupts are enabled.

Top module: `mpuart_rx`

## Requirements
- R1: After reset the data output is 0, and the full, parity-error, framing-error, overrun-error, address-marker and interrupt outputs are all 0.
- R2: A low line seen on a tick while idle is a start candidate. If the line is high at the eighth tick after detection, the receiver returns to idle and no frame completes.
- R3: The eight data bits are sampled 16 ticks apart, the first one 16 ticks after the start check. The first bit on the line lands in data_o[0].
- R4: In normal mode with par_en_i=1 a ninth bit is received. The expected ninth bit is the XOR of the eight data bits when par_odd_i=0, and its inverse when par_odd_i=1. A mismatch sets par_err_o.
- R5: In multiprocessor mode (mp_mode_i=1) a ninth bit is always received and stored in adr_o, and par_err_o is never set, whatever par_en_i is. In normal mode a completed frame sets adr_o to 0.
- R6: A low line at the stop-bit sample sets frm_err_o.
- R7: Every completed frame that finds full_o=0 stores its byte and sets full_o, whether it had errors or not. The error flags are sticky.
- R8: A frame that completes while full_o=1 sets ovr_err_o and is dropped whole. data_o, adr_o and the other error flags keep their values.
- R9: A pulse on rd_i clears full_o on the next edge. A pulse on clr_err_i clears par_err_o, frm_err_o and ovr_err_o on the next edge.
- R10: irq_o is 1 exactly while irq_en_i=1 and full_o=1.
- R11: While rx_en_i=0 the line is ignored and any frame in progress is abandoned, so no frame completes and no output changes.
- R12: In normal mode with par_en_i=0 the stop bit directly follows the eighth data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rx_en_i | input | 1 | Receive enable |
| mp_mode_i | input | 1 | 1 = multiprocessor mode, 0 = normal mode |
| par_en_i | input | 1 | Parity enable (normal mode) |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en_i | input | 1 | Receive interrupt enable |
| rxd_i | input | 1 | Serial input line, idle high |
| rd_i | input | 1 | Host data read strobe |
| clr_err_i | input | 1 | Error flag clear strobe |
| data_o | output | DATA_BITS (8) | Received byte |
| full_o | output | 1 | Receive data full |
| par_err_o | output | 1 | Parity error |
| frm_err_o | output | 1 | Framing error |
| ovr_err_o | output | 1 | Overrun error |
| adr_o | output | 1 | Received address/data marker |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with DATA_BITS=8, OVS=16 and SYNC_STAGES=2, and issues a tick every fourth clock. With those values every start check, bit sample and stop sample falls on a known clock edge, and the bench reference model predicts it by counting ticks. The short tick interval keeps each frame to a few hundred clocks. That leaves room in one run for parity in both senses, both modes, framing errors, overrun, false starts and receiving disabled in the middle of a frame.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  // Value the ninth bit must carry for a good frame: even parity makes the
  // total count of ones even, odd parity makes it odd.
  function automatic logic expected_ninth(input logic [15:0] payload, input logic odd);
    return (^payload) ^ odd;
  endfunction

  // A ninth bit follows the data in multiprocessor mode, or with parity on.
  function automatic logic ninth_present(input logic mp, input logic pen);
    return mp | pen;
  endfunction

endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= 1'b1;
        else        pipe_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mpuart_rx_frame.sv
module mpuart_rx_frame
  import mpuart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_en_i,
  input  logic                 mp_mode_i,
  input  logic                 par_en_i,
  input  logic                 line_i,
  output logic                 done_o,
  output logic                 abort_o,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ninth_o,
  output logic                 stop_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rx_state_e             st_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic [DATA_BITS-1:0]  shift_q;
  logic                  ninth_q;
  logic                  step;
  logic                  at_half;
  logic                  at_full;

  always_comb begin
    step    = tick_i & rx_en_i;
    at_half = (cnt_q == HALF_LAST);
    at_full = (cnt_q == FULL_LAST);
    done_o  = step && (st_q == RX_STOP) && at_full;
    abort_o = step && (st_q == RX_START) && at_half && line_i;
    busy_o  = (st_q != RX_IDLE);
    data_o  = shift_q;
    ninth_o = ninth_q;
    stop_o  = line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      ninth_q <= 1'b0;
    end else if (!rx_en_i) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
    end else if (tick_i) begin
      case (st_q)
        RX_IDLE: begin
          if (!line_i) begin
            st_q    <= RX_START;
            cnt_q   <= '0;
            ninth_q <= 1'b0;
          end
        end
        RX_START: begin
          if (at_half) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= line_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_full) begin
            cnt_q   <= '0;
            shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
            if (bit_q == LAST_BIT)
              st_q <= ninth_present(mp_mode_i, par_en_i) ? RX_NINTH : RX_STOP;
            else
              bit_q <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_NINTH: begin
          if (at_full) begin
            cnt_q   <= '0;
            ninth_q <= line_i;
            st_q    <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpuart_rx_status.sv
module mpuart_rx_status
  import mpuart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 ninth_i,
  input  logic                 stop_i,
  input  logic                 mp_mode_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  input  logic                 rd_i,
  input  logic                 clr_err_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o,
  output logic                 par_err_o,
  output logic                 frm_err_o,
  output logic                 ovr_err_o,
  output logic                 adr_o
);
  logic held;
  logic accept;
  logic overrun;
  logic bad_parity;

  always_comb begin
    held       = full_o & ~rd_i;
    accept     = done_i & ~held;
    overrun    = done_i & held;
    bad_parity = par_en_i & ~mp_mode_i &
                 (ninth_i != expected_ninth(16'(data_i), par_odd_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o    <= '0;
      full_o    <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
      adr_o     <= 1'b0;
    end else begin
      full_o    <= accept | held;
      par_err_o <= (par_err_o & ~clr_err_i) | (accept & bad_parity);
      frm_err_o <= (frm_err_o & ~clr_err_i) | (accept & ~stop_i);
      ovr_err_o <= (ovr_err_o & ~clr_err_i) | overrun;
      if (accept) begin
        data_o <= data_i;
        adr_o  <= mp_mode_i & ninth_i;
      end
    end
  end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_en_i,
  input  logic                 mp_mode_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  input  logic                 irq_en_i,
  input  logic                 rxd_i,
  input  logic                 rd_i,
  input  logic                 clr_err_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o,
  output logic                 par_err_o,
  output logic                 frm_err_o,
  output logic                 ovr_err_o,
  output logic                 adr_o,
  output logic                 irq_o
);
  logic                 line;
  logic                 frame_done;
  logic                 start_abort;
  logic                 busy;
  logic [DATA_BITS-1:0] frame_data;
  logic                 frame_ninth;
  logic                 stop_ok;

  mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd_i),
    .dout (line)
  );

  mpuart_rx_frame #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .rx_en_i  (rx_en_i),
    .mp_mode_i(mp_mode_i),
    .par_en_i (par_en_i),
    .line_i   (line),
    .done_o   (frame_done),
    .abort_o  (start_abort),
    .busy_o   (busy),
    .data_o   (frame_data),
    .ninth_o  (frame_ninth),
    .stop_o   (stop_ok)
  );

  mpuart_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (frame_done),
    .data_i   (frame_data),
    .ninth_i  (frame_ninth),
    .stop_i   (stop_ok),
    .mp_mode_i(mp_mode_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .rd_i     (rd_i),
    .clr_err_i(clr_err_i),
    .data_o   (data_o),
    .full_o   (full_o),
    .par_err_o(par_err_o),
    .frm_err_o(frm_err_o),
    .ovr_err_o(ovr_err_o),
    .adr_o    (adr_o)
  );

  assign irq_o = irq_en_i & full_o;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_i,
  input logic          mp_mode_i,
  input logic          irq_en_i,
  input logic          rd_i,
  input logic          clr_err_i,
  input logic [DW-1:0] data_o,
  input logic          full_o,
  input logic          par_err_o,
  input logic          frm_err_o,
  input logic          ovr_err_o,
  input logic          irq_o,
  input logic          frame_done,
  input logic          start_abort,
  input logic          stop_ok,
  input logic          busy
);
  // R10
  irq_follows_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full_o) && irq_en_i) |-> irq_o);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  // R9
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !frame_done) |=> !full_o);

  // R9
  clear_errors_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err_i && !frame_done) |=> (!par_err_o && !frm_err_o && !ovr_err_o));

  // R8
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && full_o && !rd_i) |=> (ovr_err_o && $stable(data_o)));

  // R7
  done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !full_o) |=> full_o);

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_ok && !full_o) |=> frm_err_o);

  // R5
  mp_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_mode_i && !par_err_o) |=> !par_err_o);

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !busy);

  // R2
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |-> !frame_done);
endmodule

bind mpuart_rx mpuart_rx_chk #(.DW(DATA_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en_i    (rx_en_i),
  .mp_mode_i  (mp_mode_i),
  .irq_en_i   (irq_en_i),
  .rd_i       (rd_i),
  .clr_err_i  (clr_err_i),
  .data_o     (data_o),
  .full_o     (full_o),
  .par_err_o  (par_err_o),
  .frm_err_o  (frm_err_o),
  .ovr_err_o  (ovr_err_o),
  .irq_o      (irq_o),
  .frame_done (frame_done),
  .start_abort(start_abort),
  .stop_ok    (stop_ok),
  .busy       (busy)
);

// File: tb/tb_mpuart_rx.sv
`timescale 1ns/1ps
module tb_mpuart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_en = 1'b1;
  logic       mp = 1'b0;
  logic       pen = 1'b0;
  logic       podd = 1'b0;
  logic       irq_en = 1'b0;
  logic       rxd = 1'b1;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] data_o;
  logic       full_o, par_err_o, frm_err_o, ovr_err_o, adr_o, irq_o;

  int ntests = 0;
  int nfail  = 0;
  int tcount = 0;
  int divc   = 0;
  bit finished = 0;

  typedef struct {
    int         due;
    logic [7:0] d;
    logic       nine;
    logic       stop;
  } frame_t;
  frame_t pend[$];

  logic [7:0] e_data;
  logic e_full, e_pe, e_fe, e_oe, e_adr;

  mpuart_rx #(.DATA_BITS(8), .OVS(16), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_en_i(rx_en),
    .mp_mode_i(mp), .par_en_i(pen), .par_odd_i(podd), .irq_en_i(irq_en),
    .rxd_i(rxd), .rd_i(rd), .clr_err_i(clr),
    .data_o(data_o), .full_o(full_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o), .ovr_err_o(ovr_err_o), .adr_o(adr_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    divc   = (divc == 3) ? 0 : divc + 1;
    tick_i = (divc == 0);
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: frames complete on a known tick index.
  always @(posedge clk) begin
    if (!rst_n) begin
      e_data = '0; e_full = 0; e_pe = 0; e_fe = 0; e_oe = 0; e_adr = 0;
      tcount = 0;
    end else begin
      logic n_full, n_pe, n_fe, n_oe;
      n_full = e_full && !rd;
      n_pe = e_pe && !clr;
      n_fe = e_fe && !clr;
      n_oe = e_oe && !clr;
      if (tick_i) tcount++;
      if (tick_i && pend.size() > 0 && pend[0].due == tcount) begin
        frame_t f;
        f = pend.pop_front();
        if (e_full && !rd) n_oe = 1;
        else begin
          e_data = f.d;
          e_adr  = mp ? f.nine : 1'b0;
          n_full = 1;
          if (pen && !mp) begin
            int ones;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += f.d[i];
            if (f.nine != (((ones % 2) == 1) ^ podd)) n_pe = 1;
          end
          if (!f.stop) n_fe = 1;
        end
      end
      e_full = n_full; e_pe = n_pe; e_fe = n_fe; e_oe = n_oe;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "data_o", data_o, e_data);
      chk("R7", "full_o", full_o, e_full);
      chk("R4", "par_err_o", par_err_o, e_pe);
      chk("R6", "frm_err_o", frm_err_o, e_fe);
      chk("R8", "ovr_err_o", ovr_err_o, e_oe);
      chk("R5", "adr_o", adr_o, e_adr);
      chk("R10", "irq_o", irq_o, irq_en && e_full);
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (!tick_i) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) wait_tick();
  endtask

  task automatic send(input logic [7:0] d, input logic nine, input logic stop_v,
                      input bit expect_done);
    bit has9;
    frame_t f;
    has9 = mp || pen;
    wait_tick();
    if (expect_done) begin
      f.due  = tcount + 1 + 8 + 16 * (has9 ? 10 : 9);
      f.d    = d;
      f.nine = nine;
      f.stop = stop_v;
      pend.push_back(f);
    end
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (has9) begin
      rxd = nine;
      wait_ticks(16);
    end
    rxd = stop_v;
    wait_ticks(16);
    rxd = 1'b1;
    wait_ticks(24);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "reset data", data_o, 0);
    chk("R1", "reset flags", {full_o, par_err_o, frm_err_o, ovr_err_o, adr_o, irq_o}, 0);
    rst_n = 1'b1;
    irq_en = 1'b1;
    wait_ticks(4);

    // R12 R3 plain eight-bit frame
    send(8'hA5, 1'b0, 1'b1, 1);
    chk("R3", "byte A5", data_o, 8'hA5);
    chk("R12", "full after 10-bit frame", full_o, 1);
    chk("R10", "irq with full", irq_o, 1);
    pulse_rd();
    chk("R9", "full cleared by read", full_o, 0);
    chk("R10", "irq drops", irq_o, 0);

    // R4 even parity, correct
    pen = 1'b1; podd = 1'b0;
    send(8'h3C, 1'b0, 1'b1, 1);
    chk("R4", "even parity good", par_err_o, 0);
    chk("R3", "byte 3C", data_o, 8'h3C);
    pulse_rd();

    // R4 odd parity, wrong ninth bit; R7 full still set
    podd = 1'b1;
    send(8'h01, 1'b1, 1'b1, 1);
    chk("R4", "odd parity bad", par_err_o, 1);
    chk("R7", "full despite error", full_o, 1);
    pulse_rd();
    chk("R7", "error sticky after read", par_err_o, 1);
    pulse_clr();
    chk("R9", "errors cleared", {par_err_o, frm_err_o, ovr_err_o}, 0);

    // R5 multiprocessor mode with parity enable ignored
    mp = 1'b1;
    send(8'h7E, 1'b1, 1'b1, 1);
    chk("R5", "address marker 1", adr_o, 1);
    chk("R5", "no parity check", par_err_o, 0);
    pulse_rd();
    send(8'h81, 1'b0, 1'b1, 1);
    chk("R5", "address marker 0", adr_o, 0);
    chk("R3", "byte 81", data_o, 8'h81);
    pulse_rd();
    send(8'h80, 1'b1, 1'b1, 1);
    chk("R5", "marker set again", adr_o, 1);
    pulse_rd();
    mp = 1'b0; pen = 1'b0;
    send(8'h42, 1'b0, 1'b1, 1);
    chk("R5", "normal mode clears marker", adr_o, 0);
    pulse_rd();

    // R6 framing error
    send(8'h55, 1'b0, 1'b0, 1);
    chk("R6", "stop low", frm_err_o, 1);
    chk("R7", "full with framing error", full_o, 1);
    chk("R3", "byte 55", data_o, 8'h55);
    pulse_rd();
    pulse_clr();

    // R8 overrun keeps first byte
    send(8'h11, 1'b0, 1'b1, 1);
    send(8'h22, 1'b0, 1'b0, 1);
    chk("R8", "overrun flag", ovr_err_o, 1);
    chk("R8", "first byte kept", data_o, 8'h11);
    chk("R8", "dropped frame framing ignored", frm_err_o, 0);
    pulse_rd();
    pulse_clr();

    // R2 false start
    wait_tick();
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    chk("R2", "glitch gives no frame", full_o, 0);
    send(8'hC3, 1'b0, 1'b1, 1);
    chk("R2", "frame after glitch", data_o, 8'hC3);
    pulse_rd();

    // R11 disabled for a whole frame
    rx_en = 1'b0;
    send(8'hF0, 1'b0, 1'b1, 0);
    chk("R11", "disabled frame ignored", full_o, 0);
    chk("R11", "data unchanged", data_o, 8'hC3);
    rx_en = 1'b1;
    wait_ticks(8);

    // R11 disabled mid-frame
    wait_tick();
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 3; i++) begin
      rxd = i[0];
      wait_ticks(16);
    end
    rx_en = 1'b0;
    rxd = 1'b0;
    wait_ticks(16 * 6);
    rxd = 1'b1;
    wait_ticks(24);
    rx_en = 1'b1;
    wait_ticks(40);
    chk("R11", "aborted frame", full_o, 0);
    chk("R11", "aborted data", data_o, 8'hC3);

    // R10 interrupt masked
    irq_en = 1'b0;
    send(8'h5A, 1'b0, 1'b1, 1);
    chk("R10", "masked irq", irq_o, 0);
    chk("R7", "full without irq", full_o, 1);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10", "irq on enable", irq_o, 1);
    pulse_rd();

    wait_ticks(4);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
    end
  end
endmodule